// File: doc/BRIEF.md
# Analog Output Card Host Register Decoder

This block sits behind the 16-bit host I/O window of a multi-channel analog output card. It decodes the host's byte offset into three configuration words, a status word, an 8-bit digital I/O port, a waveform FIFO port and one data holding register per DAC channel. A bank-select bit in the first configuration word changes what the lowest three offsets do. With the bank set, writes to those offsets no longer store data. Each write instead clears one sticky interrupt flag.

The converters, the FIFO storage and the timer chip are outside the block. The FIFO is seen only through its three level flags and two strobes: one pushes a word and one flushes the FIFO. Event inputs set the sticky flags. The configuration words are presented on output ports for the rest of the card. Each DAC register drives a slice of a wide data bus, together with a one-cycle load pulse.

Top module: `aocard_regs`

## Requirements
- R1: After reset, the following are all zero: `dio_out`, `dio_oe`, all three configuration outputs, every DAC data slice, all sticky flags and `irq`. The normal bank is therefore selected.
- R2: A read at offset 0x0A returns the status word combinationally. The bit layout is: bit 6 FIFO half-full, bit 5 FIFO empty, bit 4 FIFO full, bit 3 interrupt-2 flag, bit 2 interrupt-1 flag, bit 1 terminal-count flag, bit 0 serial PROM data. Bits 15:7 read as zero.
- R3: In the normal bank, a write to offset 0x00 stores bits 7:0 into `dio_out` on the next clock edge. A read at 0x00 returns `dio_pin_in` in bits 7:0, with zeros above.
- R4: `dio_oe[3:0]` follows bit 2 of config-3 (offset 0x04). `dio_oe[7:4]` follows bit 3 of config-3.
- R5: In the normal bank, a write to 0x0C asserts `fifo_push` in that same cycle. A read at 0x0C asserts `fifo_flush` in that same cycle, in either bank.
- R6: Bit 7 of config-1 (offset 0x0A, writable in both banks) selects the alternate bank. While it is set, writes to 0x00, 0x02 and 0x04 clear the terminal-count, interrupt-1 and interrupt-2 flags respectively. These writes leave `dio_out`, config-2 and config-3 unchanged.
- R7: Each flag is set by a one-cycle pulse on its event input and stays set until it is cleared. If a set and a clear arrive in the same cycle, the set wins.
- R8: `irq` is high when any enabled flag is set. Config-1 bit 11 enables the terminal-count flag. Bit 12 or bit 14 enables the interrupt-1 flag. Bit 13 or bit 15 enables the interrupt-2 flag.
- R9: A write to offset 0x0C+2n, for n from 1 to NCH-1, loads bits 11:0 into DAC slice n in either bank. `dac_load[n]` is high for exactly the one cycle after the write edge.
- R10: DAC channel 0 shares offset 0x0C with the FIFO. Its data register is written only while the alternate bank is selected, and in that case `fifo_push` stays low.
- R11: In the normal bank, writes to 0x02 and 0x04 store the whole word into config-2 and config-3. Config-1 stores on a write to 0x0A. All three appear on their output ports from the next cycle.
- R12: Any access with `bus_addr[0]` set is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 5 | Host byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational |
| dio_pin_in | input | 8 | Sampled DIO pin levels |
| dio_out | output | 8 | DIO output latch |
| dio_oe | output | 8 | DIO driver enables |
| fifo_half | input | 1 | FIFO half-full flag |
| fifo_empty | input | 1 | FIFO empty flag |
| fifo_full | input | 1 | FIFO full flag |
| fifo_push | output | 1 | Push bus_wdata into FIFO |
| fifo_flush | output | 1 | Flush FIFO |
| prom_sdo | input | 1 | Serial PROM data out |
| ev_tc | input | 1 | Terminal-count event |
| ev_int1 | input | 1 | Interrupt-1 event |
| ev_int2 | input | 1 | Interrupt-2 event |
| irq | output | 1 | Combined interrupt request |
| cfg1_q | output | 16 | Config-1 contents |
| cfg2_q | output | 16 | Config-2 contents |
| cfg3_q | output | 16 | Config-3 contents |
| dac_data | output | NCH*12 | DAC data, channel n in bits 12n+11:12n |
| dac_load | output | NCH | One-cycle load pulse per channel |

## Verification
The status readback is driven from a table of FIFO-flag and PROM-bit patterns. Each pattern isolates one status bit or mixes several, so any swap of bit positions shows up. The same offsets 0x00, 0x02, 0x04 and 0x0C are written once with the bank clear and once with it set. This separates storing from flag clearing, and DAC channel 0 from the FIFO push. The remaining directed cases are the set-versus-clear collision, the alternative interrupt enable bits, a DAC write outside the bank-switched range, and an odd offset.

// File: rtl/aocard_regs.sv
module aocard_regs #(
  parameter int NCH = 10,
  parameter int DW  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  input  logic [7:0]        dio_pin_in,
  output logic [7:0]        dio_out,
  output logic [7:0]        dio_oe,
  input  logic              fifo_half,
  input  logic              fifo_empty,
  input  logic              fifo_full,
  output logic              fifo_push,
  output logic              fifo_flush,
  input  logic              prom_sdo,
  input  logic              ev_tc,
  input  logic              ev_int1,
  input  logic              ev_int2,
  output logic              irq,
  output logic [15:0]       cfg1_q,
  output logic [15:0]       cfg2_q,
  output logic [15:0]       cfg3_q,
  output logic [NCH*DW-1:0] dac_data,
  output logic [NCH-1:0]    dac_load
);
  localparam int W_DIO = 0, W_CFG2 = 1, W_CFG3 = 2, W_CFG1 = 5, W_DAC = 6;

  wire [3:0] w    = bus_addr[4:1];
  wire       even = ~bus_addr[0];
  wire       grp2 = cfg1_q[7];
  wire       wr1  = bus_wr & even & ~grp2;
  wire       wr2  = bus_wr & even & grp2;

  wire clr_tc   = wr2 && w == 4'(W_DIO);
  wire clr_int1 = wr2 && w == 4'(W_CFG2);
  wire clr_int2 = wr2 && w == 4'(W_CFG3);

  logic tc_f, int1_f, int2_f;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tc_f <= 1'b0; int1_f <= 1'b0; int2_f <= 1'b0;
      cfg1_q <= '0; cfg2_q <= '0; cfg3_q <= '0; dio_out <= '0;
    end else begin
      tc_f   <= ev_tc   | (tc_f   & ~clr_tc);
      int1_f <= ev_int1 | (int1_f & ~clr_int1);
      int2_f <= ev_int2 | (int2_f & ~clr_int2);
      if (bus_wr && even && w == 4'(W_CFG1)) cfg1_q <= bus_wdata;
      if (wr1 && w == 4'(W_CFG2)) cfg2_q <= bus_wdata;
      if (wr1 && w == 4'(W_CFG3)) cfg3_q <= bus_wdata;
      if (wr1 && w == 4'(W_DIO))  dio_out <= bus_wdata[7:0];
    end
  end

  assign dio_oe     = {{4{cfg3_q[3]}}, {4{cfg3_q[2]}}};
  assign fifo_push  = wr1 && w == 4'(W_DAC);
  assign fifo_flush = bus_rd && even && w == 4'(W_DAC);

  assign irq = (tc_f & cfg1_q[11])
             | (int1_f & (cfg1_q[12] | cfg1_q[14]))
             | (int2_f & (cfg1_q[13] | cfg1_q[15]));

  always_comb begin
    bus_rdata = '0;
    if (bus_rd && even) begin
      if (w == 4'(W_DIO))
        bus_rdata = {8'h00, dio_pin_in};
      else if (w == 4'(W_CFG1))
        bus_rdata = {9'b0, fifo_half, fifo_empty, fifo_full, int2_f, int1_f, tc_f, prom_sdo};
    end
  end

  for (genvar n = 0; n < NCH; n++) begin : g_dac
    wire hit = bus_wr && even && (int'(w) == W_DAC + n) && ((n != 0) || grp2);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        dac_data[n*DW +: DW] <= '0;
        dac_load[n]          <= 1'b0;
      end else begin
        dac_load[n] <= hit;
        if (hit) dac_data[n*DW +: DW] <= bus_wdata[DW-1:0];
      end
    end
  end
endmodule

module aocard_regs_chk #(
  parameter int NCH = 10
) (
  input logic           clk,
  input logic           rst_n,
  input logic [4:0]     bus_addr,
  input logic           bus_wr,
  input logic           grp2,
  input logic           tc_f,
  input logic           int1_f,
  input logic           int2_f,
  input logic           ev_tc,
  input logic           irq,
  input logic [7:0]     dio_out,
  input logic [NCH-1:0] dac_load,
  input logic           fifo_push
);
  AST_LOAD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dac_load)); // R9
  AST_DAC0_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == 5'h0C && !grp2 |=> !dac_load[0]); // R10
  AST_PUSH_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_push |-> !grp2); // R10
  AST_TC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    tc_f && !(bus_wr && grp2 && bus_addr == 5'h00) |=> tc_f); // R7
  AST_TC_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tc |=> tc_f); // R7
  AST_IRQ_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (tc_f || int1_f || int2_f)); // R8
  AST_DIO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && !grp2 && bus_addr == 5'h00) |=> $stable(dio_out)); // R6
endmodule

bind aocard_regs aocard_regs_chk #(.NCH(NCH)) u_chk (.*);

// File: tb/aocard_regs_test.sv
module aocard_regs_test;
  localparam int NCH = 10;
  logic clk = 0, rst_n = 0;
  logic [4:0] bus_addr = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [15:0] bus_wdata = 0, bus_rdata;
  logic [7:0] dio_pin_in = 0, dio_out, dio_oe;
  logic fifo_half = 0, fifo_empty = 0, fifo_full = 0, fifo_push, fifo_flush;
  logic prom_sdo = 0, ev_tc = 0, ev_int1 = 0, ev_int2 = 0, irq;
  logic [15:0] cfg1_q, cfg2_q, cfg3_q;
  logic [NCH*12-1:0] dac_data;
  logic [NCH-1:0] dac_load;

  aocard_regs #(.NCH(NCH)) uut (.*);

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic got_push, got_flush;
  logic [15:0] rv;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    #1 got_push = fifo_push;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [4:0] a);
    @(negedge clk);
    bus_addr = a; bus_rd = 1;
    #1 rv = bus_rdata; got_flush = fifo_flush;
    #1 bus_rd = 0;
  endtask

  localparam int NV = 5;
  localparam logic [19:0] VEC [NV] = '{
    {4'b1000, 16'h0040}, {4'b0100, 16'h0020}, {4'b0010, 16'h0010},
    {4'b0001, 16'h0001}, {4'b1101, 16'h0061}};

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 dio_out", dio_out, 0);
    check("R1 dio_oe", dio_oe, 0);
    check("R1 irq", irq, 0);
    check("R1 cfg1", cfg1_q, 0);
    check("R1 dac", dac_data[31:0], 0);
    rd(5'h0A); check("R1 status", rv, 0);

    // R2 status table
    for (int i = 0; i < NV; i++) begin
      {fifo_half, fifo_empty, fifo_full, prom_sdo} = VEC[i][19:16];
      rd(5'h0A);
      check("R2 status", rv, VEC[i][15:0]);
    end
    {fifo_half, fifo_empty, fifo_full, prom_sdo} = 4'b0;

    // R3 DIO
    wr(5'h00, 16'hFFA5); check("R3 dio_out", dio_out, 8'hA5);
    dio_pin_in = 8'h3C; rd(5'h00); check("R3 pins", rv, 16'h003C);

    // R4 / R11 config-3
    wr(5'h04, 16'h0004); check("R4 oe low", dio_oe, 8'h0F);
    wr(5'h04, 16'h0008); check("R4 oe high", dio_oe, 8'hF0);
    wr(5'h04, 16'h000C); check("R4 oe both", dio_oe, 8'hFF);
    check("R11 cfg3", cfg3_q, 16'h000C);
    wr(5'h02, 16'h0003); check("R11 cfg2", cfg2_q, 16'h0003);

    // R5 / R10 FIFO path in normal bank
    wr(5'h0C, 16'h1234);
    check("R5 push", got_push, 1);
    check("R10 no dac0 load", dac_load, 0);
    check("R10 dac0 held", dac_data[11:0], 0);
    rd(5'h0C); check("R5 flush", got_flush, 1);

    // R7 / R8 flags and enables
    @(negedge clk); ev_tc = 1; ev_int1 = 1; ev_int2 = 1;
    @(negedge clk); ev_tc = 0; ev_int1 = 0; ev_int2 = 0;
    rd(5'h0A); check("R7 flags set", rv, 16'h000E);
    check("R8 irq disabled", irq, 0);
    wr(5'h0A, 16'h0800); check("R8 irq tc", irq, 1);
    check("R11 cfg1", cfg1_q, 16'h0800);

    // R6 alternate bank clears
    wr(5'h0A, 16'h0880);
    wr(5'h00, 16'h0000);
    check("R8 irq after tc clear", irq, 0);
    check("R6 dio kept", dio_out, 8'hA5);
    rd(5'h0A); check("R6 tc clear", rv, 16'h000C);
    wr(5'h02, 16'h0000); rd(5'h0A); check("R6 int1 clear", rv, 16'h0008);
    check("R6 cfg2 kept", cfg2_q, 16'h0003);
    wr(5'h04, 16'h0000); rd(5'h0A); check("R6 int2 clear", rv, 16'h0000);
    check("R6 cfg3 kept", cfg3_q, 16'h000C);

    // R10 DAC channel 0 in alternate bank
    wr(5'h0C, 16'hFABC);
    check("R10 push low", got_push, 0);
    check("R10 dac0 load", dac_load, 10'h001);
    check("R10 dac0 data", dac_data[11:0], 12'hABC);
    @(negedge clk); check("R9 load one cycle", dac_load, 0);

    // R7 set wins over clear
    @(negedge clk);
    bus_addr = 5'h02; bus_wdata = 0; bus_wr = 1; ev_int1 = 1;
    @(negedge clk);
    bus_wr = 0; ev_int1 = 0;
    rd(5'h0A); check("R7 set wins", rv, 16'h0004);

    // R9 DAC channel 1 in normal bank
    wr(5'h0A, 16'h0000);
    wr(5'h0E, 16'hF123);
    check("R9 dac1 load", dac_load, 10'h002);
    check("R9 dac1 data", dac_data[23:12], 12'h123);
    wr(5'h1E, 16'h0456);
    check("R9 dac9 data", dac_data[119:108], 12'h456);

    // R12 odd offset ignored
    wr(5'h01, 16'h00FF); check("R12 odd ignored", dio_out, 8'hA5);

    // R8 alternate enable bit for int1
    wr(5'h0A, 16'h4000); check("R8 irq ext1", irq, 1);

    // R1 reset again
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    check("R1 irq after reset", irq, 0);
    check("R1 cfg1 after reset", cfg1_q, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule